// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block evaluates one of sixteen compare predicates on two IEEE-754 operands, either both in single precision or both in double precision. Each predicate is a set of accepted relations drawn from unordered, equal and less-than, plus a flag that selects the signalling form. The block reports three things: whether the predicate holds, which condition-code slot the result is meant for, and an exception cause vector in which only the invalid-operation bit can ever be set.

A request is presented with `valid_i`. One clock later the result appears on registered outputs, with `valid_o` high for that cycle. While no request is present, the result outputs keep their last values. Operands are 64-bit words. In single-precision mode only bits 31:0 of each word are used.

Top module: `fp_cmp_unit`

## Requirements
- R1: The low three bits of `pred_i` form an accept mask: bit 0 accepts unordered, bit 1 accepts equal, bit 2 accepts less-than (a below b). `cond_o` is 1 exactly when at least one accepted relation holds. At most one of the three relations holds for any operand pair.
- R2: Predicate mask 000 always gives `cond_o`=0. Mask 111 gives 1 for every pair except a > b.
- R3: When `pred_i[3]`=1 (signalling form), any NaN in either operand sets the invalid bit `cause_o[4]`. The relation set used is the same as for the quiet form with the same low bits.
- R4: When `pred_i[3]`=0 (quiet form), only a signalling NaN sets `cause_o[4]`. A quiet NaN only makes the pair unordered. A NaN has an all-ones exponent and a non-zero fraction. It is signalling when the fraction's top bit (bit 51 for double, bit 22 for single) is 0.
- R5: `cause_o` bits 3:0 (divide-by-zero, overflow, underflow, inexact) are always 0. A compare raises at most the invalid cause at bit 4.
- R6: `cc_o` returns the 3-bit condition-code index `cc_sel_i` captured with the request.
- R7: +0 and -0 compare equal.
- R8: Ordering is sign-magnitude: a negative operand is below a positive one. Between two negative operands the larger magnitude is lower.
- R9: Infinities are ordered like extreme finite values and never make a pair unordered.
- R10: With `dbl_i`=0 the operands are the low 32 bits of each word. Bits 63:32 have no effect on the result.
- R11: `valid_o` equals `valid_i` delayed by one clock. After reset all outputs are 0. Without a request, `cond_o`, `cc_o` and `cause_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Compare request |
| dbl_i | input | 1 | 1 = double precision, 0 = single |
| pred_i | input | 4 | Predicate: [2:0] accept mask, [3] signalling |
| cc_sel_i | input | 3 | Condition-code index for this compare |
| opa_i | input | 64 | Operand a |
| opb_i | input | 64 | Operand b |
| valid_o | output | 1 | Result valid, one cycle after request |
| cond_o | output | 1 | Predicate result |
| cc_o | output | 3 | Captured condition-code index |
| cause_o | output | 5 | Cause vector, bit 4 = invalid |

## Verification
Directed pairs are tried in both precisions and in both predicate forms:
- Ordered finite values with mixed signs tell the sign-magnitude ordering apart from a plain unsigned compare.
- Opposite zeros tell equality by value apart from equality of bits.
- Infinities against finite values show that they stay ordered.
- Quiet and signalling NaNs under quiet and signalling predicates separate the two invalid rules.

Further checks cover the remaining behaviours:
- Single-precision pairs with garbage in the upper halves show that those halves are ignored.
- Idle cycles between requests confirm that the outputs hold.
- A long random run compares every predicate against a behavioural model built on signed ordering keys. Its operands mix special values with random words.

// File: rtl/fp_cmp_pkg.sv
package fp_cmp_pkg;
  parameter int unsigned WORD_W   = 64;
  parameter int unsigned MAG_W    = WORD_W - 1;
  parameter int unsigned SP_EXP_W = 8;
  parameter int unsigned SP_FRC_W = 23;
  parameter int unsigned DP_EXP_W = 11;
  parameter int unsigned DP_FRC_W = 52;
  parameter int unsigned PRED_W   = 4;
  parameter int unsigned CC_W     = 3;
  parameter int unsigned CAUSE_W  = 5;

  localparam int unsigned PB_UN   = 0;
  localparam int unsigned PB_EQ   = 1;
  localparam int unsigned PB_LT   = 2;
  localparam int unsigned PB_SIG  = 3;
  localparam int unsigned CB_INV  = 4;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             snan;
    logic [MAG_W-1:0] mag;
  } op_class_t;
endpackage

// File: rtl/fp_operand_decode.sv
module fp_operand_decode
  import fp_cmp_pkg::*;
#(
  parameter int unsigned EXP_W = 11,
  parameter int unsigned FRC_W = 52,
  localparam int unsigned OP_W = EXP_W + FRC_W + 1
) (
  input  logic [OP_W-1:0] op_i,
  output op_class_t       cls_o
);
  logic [EXP_W-1:0] exp_f;
  logic [FRC_W-1:0] frc_f;

  assign exp_f = op_i[OP_W-2 -: EXP_W];
  assign frc_f = op_i[FRC_W-1:0];

  always_comb begin
    cls_o      = '0;
    cls_o.sign = op_i[OP_W-1];
    cls_o.nan  = (&exp_f) && (|frc_f);
    cls_o.snan = cls_o.nan && !frc_f[FRC_W-1];
    // exponent:fraction as one unsigned magnitude key
    cls_o.mag  = MAG_W'(op_i[OP_W-2:0]);
  end
endmodule

// File: rtl/fp_relation.sv
module fp_relation
  import fp_cmp_pkg::*;
(
  input  op_class_t a_i,
  input  op_class_t b_i,
  output logic      un_o,
  output logic      eq_o,
  output logic      lt_o
);
  logic both_zero, mag_lt, mag_gt, neg_lt;

  assign both_zero = (a_i.mag == '0) && (b_i.mag == '0);
  assign mag_lt    = a_i.mag < b_i.mag;
  assign mag_gt    = a_i.mag > b_i.mag;

  always_comb begin
    unique case ({a_i.sign, b_i.sign})
      2'b00:   neg_lt = mag_lt;
      2'b11:   neg_lt = mag_gt;
      2'b10:   neg_lt = 1'b1;
      default: neg_lt = 1'b0;
    endcase
  end

  assign un_o = a_i.nan | b_i.nan;
  assign eq_o = !un_o && (both_zero || (a_i == b_i));
  assign lt_o = !un_o && !both_zero && neg_lt;
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
  import fp_cmp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               dbl_i,
  input  logic [PRED_W-1:0]  pred_i,
  input  logic [CC_W-1:0]    cc_sel_i,
  input  logic [WORD_W-1:0]  opa_i,
  input  logic [WORD_W-1:0]  opb_i,
  output logic               valid_o,
  output logic               cond_o,
  output logic [CC_W-1:0]    cc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int unsigned SP_W = SP_EXP_W + SP_FRC_W + 1;

  op_class_t cls_sp [2];
  op_class_t cls_dp [2];
  op_class_t cls_a, cls_b;
  logic [WORD_W-1:0] ops [2];

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    fp_operand_decode #(.EXP_W(SP_EXP_W), .FRC_W(SP_FRC_W)) u_sp (
      .op_i (ops[g][SP_W-1:0]),
      .cls_o(cls_sp[g])
    );
    fp_operand_decode #(.EXP_W(DP_EXP_W), .FRC_W(DP_FRC_W)) u_dp (
      .op_i (ops[g]),
      .cls_o(cls_dp[g])
    );
  end

  assign cls_a = dbl_i ? cls_dp[0] : cls_sp[0];
  assign cls_b = dbl_i ? cls_dp[1] : cls_sp[1];

  logic rel_un, rel_eq, rel_lt;

  fp_relation u_rel (
    .a_i (cls_a),
    .b_i (cls_b),
    .un_o(rel_un),
    .eq_o(rel_eq),
    .lt_o(rel_lt)
  );

  logic               cond_d, inv_d;
  logic [CAUSE_W-1:0] cause_d;

  assign cond_d = (pred_i[PB_UN] & rel_un) | (pred_i[PB_EQ] & rel_eq) |
                  (pred_i[PB_LT] & rel_lt);
  assign inv_d  = pred_i[PB_SIG] ? rel_un : (cls_a.snan | cls_b.snan);

  always_comb begin
    cause_d         = '0;
    cause_d[CB_INV] = inv_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cond_o  <= 1'b0;
      cc_o    <= '0;
      cause_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        cond_o  <= cond_d;
        cc_o    <= cc_sel_i;
        cause_o <= cause_d;
      end
    end
  end

  // R1: relations are mutually exclusive
  a_r1_rel_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $onehot0({rel_un, rel_eq, rel_lt}));

  a_r2_mask_zero_false: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i[2:0] == 3'b000) |=> !cond_o);

  a_r3_sig_nan_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i[PB_SIG] && (cls_a.nan || cls_b.nan)) |=> cause_o[CB_INV]);

  a_r5_cause_low_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cause_o[CB_INV-1:0] == '0));

  a_r6_cc_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (cc_o == $past(cc_sel_i)));

  a_r11_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(cond_o) && $stable(cause_o) && $stable(cc_o)));
endmodule

// File: tb/fp_cmp_unit_tb_top.sv
`timescale 1ns/1ps
module fp_cmp_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dbl_i = 1'b0;
  logic [3:0]  pred_i = '0;
  logic [2:0]  cc_sel_i = '0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic        valid_o, cond_o;
  logic [2:0]  cc_o;
  logic [4:0]  cause_o;

  int checks = 0, errors = 0;
  bit exp_cond = 0, exp_inv = 0;
  logic [2:0] exp_cc = '0;

  always #2.5 clk_i = ~clk_i;

  fp_cmp_unit dut_i (.*);

  localparam logic [63:0] D_ONE = 64'h3FF0000000000000, D_TWO = 64'h4000000000000000,
    D_MONE = 64'hBFF0000000000000, D_MTWO = 64'hC000000000000000,
    D_PINF = 64'h7FF0000000000000, D_NINF = 64'hFFF0000000000000,
    D_QNAN = 64'h7FF8000000000000, D_SNAN = 64'h7FF0000000000001,
    D_PZ = 64'h0, D_NZ = 64'h8000000000000000;
  localparam logic [31:0] S_ONE = 32'h3F800000, S_TWO = 32'h40000000,
    S_MONE = 32'hBF800000, S_QNAN = 32'h7FC00000, S_SNAN = 32'h7F800001,
    S_NZ = 32'h80000000;

  function automatic logic [1:0] model(logic [63:0] a, logic [63:0] b, bit dbl, logic [3:0] p);
    bit na, nb, sa, sb, un, eq, lt;
    longint ka, kb;
    if (dbl) begin
      na = (a[62:52] == 11'h7FF) && (a[51:0] != 0); sa = na && !a[51];
      nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0); sb = nb && !b[51];
      ka = longint'({1'b0, a[62:0]}); if (a[63]) ka = -ka;
      kb = longint'({1'b0, b[62:0]}); if (b[63]) kb = -kb;
    end else begin
      na = (a[30:23] == 8'hFF) && (a[22:0] != 0); sa = na && !a[22];
      nb = (b[30:23] == 8'hFF) && (b[22:0] != 0); sb = nb && !b[22];
      ka = longint'(a[30:0]); if (a[31]) ka = -ka;
      kb = longint'(b[30:0]); if (b[31]) kb = -kb;
    end
    un = na || nb;
    eq = !un && ka == kb;
    lt = !un && ka < kb;
    return {(p[0] && un) || (p[1] && eq) || (p[2] && lt), p[3] ? un : (sa || sb)};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic cmp(logic [63:0] a, logic [63:0] b, bit dbl, logic [3:0] p,
                     logic [2:0] cc, bit vld, string tag);
    logic [1:0] r;
    @(negedge clk_i);
    valid_i = vld; dbl_i = dbl; pred_i = p; cc_sel_i = cc; opa_i = a; opb_i = b;
    if (vld) begin
      r = model(a, b, dbl, p);
      exp_cond = r[1]; exp_inv = r[0]; exp_cc = cc;
    end
    @(posedge clk_i); #1;
    chk(valid_o == vld, "R11", "valid_o", 64'(valid_o), 64'(vld));
    chk(cond_o == exp_cond, tag, "cond_o", 64'(cond_o), 64'(exp_cond));
    chk(cause_o == {exp_inv, 4'b0}, tag, "cause_o", 64'(cause_o), 64'({exp_inv, 4'b0}));
    chk(cc_o == exp_cc, tag, "cc_o", 64'(cc_o), 64'(exp_cc));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] specials [10];
    specials = '{D_ONE, D_TWO, D_MONE, D_MTWO, D_PINF, D_NINF, D_QNAN, D_SNAN, D_PZ, D_NZ};
    #12; rst_ni = 1'b1; #1;
    // R11: reset state
    chk(valid_o == 0 && cond_o == 0 && cc_o == 0 && cause_o == 0, "R11", "reset outputs",
        {55'b0, valid_o, cond_o, cc_o, cause_o}, 64'h0);

    // R1: single-relation masks
    cmp(D_ONE, D_TWO, 1, 4'h4, 3'd1, 1, "R1");
    cmp(D_ONE, D_ONE, 1, 4'h2, 3'd2, 1, "R1");
    cmp(D_QNAN, D_ONE, 1, 4'h1, 3'd3, 1, "R1");
    cmp(D_TWO, D_ONE, 1, 4'h6, 3'd4, 1, "R1");
    // R2: mask 000 and 111
    cmp(D_QNAN, D_ONE, 1, 4'h0, 3'd5, 1, "R2");
    cmp(D_ONE, D_ONE, 1, 4'h0, 3'd5, 1, "R2");
    cmp(D_QNAN, D_QNAN, 1, 4'h7, 3'd6, 1, "R2");
    cmp(D_TWO, D_ONE, 1, 4'h7, 3'd6, 1, "R2");
    // R3: signalling predicate with quiet NaN raises invalid
    cmp(D_QNAN, D_ONE, 1, 4'h8, 3'd0, 1, "R3");
    cmp(D_ONE, D_QNAN, 1, 4'hB, 3'd0, 1, "R3");
    cmp({32'h0, S_QNAN}, {32'h0, S_ONE}, 0, 4'h9, 3'd7, 1, "R3");
    // R4: quiet predicate, quiet NaN no invalid, signalling NaN invalid
    cmp(D_QNAN, D_ONE, 1, 4'h1, 3'd1, 1, "R4");
    cmp(D_SNAN, D_ONE, 1, 4'h1, 3'd1, 1, "R4");
    cmp({32'h0, S_ONE}, {32'h0, S_SNAN}, 0, 4'h3, 3'd2, 1, "R4");
    // R5: cause low bits clear on invalid and non-invalid compares
    cmp(D_SNAN, D_SNAN, 1, 4'hF, 3'd3, 1, "R5");
    // R6: cc index capture
    cmp(D_ONE, D_ONE, 1, 4'h2, 3'd7, 1, "R6");
    // R7: zeros equal
    cmp(D_PZ, D_NZ, 1, 4'h2, 3'd0, 1, "R7");
    cmp(D_NZ, D_PZ, 1, 4'h4, 3'd0, 1, "R7");
    cmp({32'h0, S_NZ}, 64'h0, 0, 4'h2, 3'd0, 1, "R7");
    // R8: sign-magnitude ordering
    cmp(D_MTWO, D_MONE, 1, 4'h4, 3'd1, 1, "R8");
    cmp(D_MONE, D_MTWO, 1, 4'h4, 3'd1, 1, "R8");
    cmp(D_MONE, D_ONE, 1, 4'h4, 3'd1, 1, "R8");
    cmp({32'h0, S_MONE}, {32'h0, S_TWO}, 0, 4'h4, 3'd1, 1, "R8");
    // R9: infinities ordered
    cmp(D_NINF, D_MTWO, 1, 4'h4, 3'd2, 1, "R9");
    cmp(D_PINF, D_PINF, 1, 4'h3, 3'd2, 1, "R9");
    cmp(D_TWO, D_PINF, 1, 4'h5, 3'd2, 1, "R9");
    // R10: upper halves ignored in single precision
    cmp({32'hFFF80000, S_ONE}, {32'h7FF00001, S_ONE}, 0, 4'hA, 3'd3, 1, "R10");
    cmp({32'h12345678, S_TWO}, {32'h0, S_ONE}, 0, 4'h4, 3'd3, 1, "R10");
    // R11: idle cycles hold outputs
    cmp(D_SNAN, D_ONE, 1, 4'h7, 3'd4, 0, "R11");
    cmp(D_QNAN, D_QNAN, 0, 4'h0, 3'd5, 0, "R11");

    // R1: random mixed run against the model
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      bit dbl;
      dbl = $urandom_range(0, 1);
      a = ($urandom_range(0, 1) != 0) ? specials[$urandom_range(0, 9)] : {$urandom, $urandom};
      b = ($urandom_range(0, 1) != 0) ? specials[$urandom_range(0, 9)] : {$urandom, $urandom};
      if (!dbl) begin
        if ($urandom_range(0, 1) != 0) a[31:0] = a[63:32];
        if ($urandom_range(0, 1) != 0) b[31:0] = b[63:32];
      end
      cmp(a, b, dbl, 4'($urandom), 3'($urandom), ($urandom_range(0, 3) != 0), "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule